// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Unit

This block multiplies two 16-bit fixed-point operands in a single clock and feeds the product into one of two 40-bit accumulators. The caller chooses one of three operations on the selected accumulator: load it with the product, add the product to it, or subtract the product from it. Each operand has its own signed or unsigned flag. Signed-by-unsigned and unsigned-by-unsigned partial products can therefore be formed when a wide multiplication is split into 16-bit pieces and summed across several cycles.

The eight guard bits above bit 31 let long accumulation runs continue without wrapping. An overflow flag reports when the selected accumulator no longer fits a 32-bit signed result. When a saturating readout is requested, the output is clamped to the nearest 32-bit signed extreme. The accumulator itself is never modified by a read, and saturation applies only to the value driven out.

Top module: `mac_dual_acc`

## Requirements
- R1: After reset both accumulators hold zero, `acc_out` is zero and `ovf_out` is low.
- R2: With `in_valid` high and `op_code` = 2'b01, the selected accumulator is loaded with the 40-bit extended product at the next clock edge.
- R3: With `in_valid` high and `op_code` = 2'b10, the extended product is added to the selected accumulator at the next clock edge.
- R4: With `in_valid` high and `op_code` = 2'b11, the extended product is subtracted from the selected accumulator at the next clock edge.
- R5: `clr` high zeroes the selected accumulator at the next edge, whatever `in_valid` and `op_code` are.
- R6: The accumulator not named by `acc_sel` keeps its value during any operation or clear.
- R7: `op_code` = 2'b00, or `in_valid` low without `clr`, leaves both accumulators unchanged.
- R8: Each operand is read as two's complement when its flag (`a_signed`, `b_signed`) is 1 and as unsigned when it is 0. The product is sign-extended to 40 bits, which gives zero extension when both operands are unsigned.
- R9: `ovf_out` is high exactly when bits 39 down to 31 of the selected accumulator are not all equal.
- R10: With `sat_rd` high and `ovf_out` high, `acc_out` is 40'h00_7FFF_FFFF for a positive accumulator (bit 39 = 0) and 40'hFF_8000_0000 for a negative one. Otherwise `acc_out` is the raw selected accumulator.
- R11: Accumulation wraps modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| a_signed | input | 1 | 1: op_a is two's complement |
| b_signed | input | 1 | 1: op_b is two's complement |
| op_code | input | 2 | 00 hold, 01 load, 10 add, 11 subtract |
| acc_sel | input | 1 | Accumulator to operate on and to read |
| clr | input | 1 | Zero the selected accumulator |
| sat_rd | input | 1 | Saturating readout enable |
| acc_out | output | 40 | Selected accumulator, optionally clamped |
| ovf_out | output | 1 | Selected accumulator exceeds 32-bit signed range |

## Verification
The bench builds the block with its defaults: two accumulators, 40-bit accumulator width, a 32-bit overflow boundary and saturation enabled. With those values, a run of a few hundred maximal unsigned products carries the accumulator past 2^40, so the modulo wrap, overflow of both signs and both clamp values can all be reached within a short test. Alternating `acc_sel` between operations exposes any leakage from one accumulator into the other.

// File: rtl/mac_dual_pkg.sv
`timescale 1ns/1ps
package mac_dual_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_LOAD = 2'b01,
    OP_ADD  = 2'b10,
    OP_SUB  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
module mac_mult #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  a,
  input  logic [OP_W-1:0]  b,
  input  logic             a_sgn,
  input  logic             b_sgn,
  output logic [ACC_W-1:0] prod_ext
);
  localparam int PW  = 2*OP_W + 2;
  localparam int EXT = ACC_W - PW;

  // each operand widened by one bit carrying its sign (or zero)
  function automatic logic signed [PW-1:0] mixed_mul(
      input logic [OP_W-1:0] x, input logic xs,
      input logic [OP_W-1:0] y, input logic ys);
    logic signed [OP_W:0] xe;
    logic signed [OP_W:0] ye;
    xe = {xs & x[OP_W-1], x};
    ye = {ys & y[OP_W-1], y};
    return PW'(xe) * PW'(ye);
  endfunction

  logic signed [PW-1:0] prod_raw;
  assign prod_raw = mixed_mul(a, a_sgn, b, b_sgn);

  generate
    if (EXT > 0) begin : g_ext
      assign prod_ext = {{EXT{prod_raw[PW-1]}}, prod_raw};
    end else begin : g_trunc
      assign prod_ext = prod_raw[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac_acc_bank.sv
`timescale 1ns/1ps
module mac_acc_bank
  import mac_dual_pkg::*;
#(
  parameter int NUM_ACC = 2,
  parameter int ACC_W   = 40,
  parameter int SEL_W   = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  mac_op_e                  op,
  input  logic [SEL_W-1:0]         sel,
  input  logic                     clr,
  input  logic [ACC_W-1:0]         prod,
  output logic [NUM_ACC*ACC_W-1:0] acc_flat
);
  function automatic logic [ACC_W-1:0] next_acc(
      input mac_op_e o, input logic [ACC_W-1:0] cur, input logic [ACC_W-1:0] p);
    case (o)
      OP_LOAD: return p;
      OP_ADD:  return cur + p;
      OP_SUB:  return cur - p;
      default: return cur;
    endcase
  endfunction

  logic [NUM_ACC-1:0] clr_hit;
  logic [NUM_ACC-1:0] upd_hit;

  genvar i;
  generate
    for (i = 0; i < NUM_ACC; i++) begin : g_acc
      logic [ACC_W-1:0] acc_q;
      assign clr_hit[i] = clr && (sel == SEL_W'(i));
      assign upd_hit[i] = !clr && in_valid && (sel == SEL_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n)          acc_q <= '0;
        else if (clr_hit[i]) acc_q <= '0;
        else if (upd_hit[i]) acc_q <= next_acc(op, acc_q, prod);
      end
      assign acc_flat[i*ACC_W +: ACC_W] = acc_q;
    end
  endgenerate
endmodule

// File: rtl/mac_readout.sv
`timescale 1ns/1ps
module mac_readout #(
  parameter int NUM_ACC = 2,
  parameter int ACC_W   = 40,
  parameter int RES_W   = 32,
  parameter int SEL_W   = 1,
  parameter bit SAT_EN  = 1'b1
) (
  input  logic [NUM_ACC*ACC_W-1:0] acc_flat,
  input  logic [SEL_W-1:0]         sel,
  input  logic                     sat_rd,
  output logic [ACC_W-1:0]         acc_out,
  output logic                     ovf_out
);
  localparam int GB = ACC_W - RES_W + 1;

  function automatic logic guard_mismatch(input logic [ACC_W-1:0] v);
    logic [GB-1:0] top;
    top = v[ACC_W-1:RES_W-1];
    return !((&top) || !(|top));
  endfunction

  function automatic logic [ACC_W-1:0] clamp(input logic [ACC_W-1:0] v);
    logic [ACC_W-1:0] lim;
    lim = {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
    return v[ACC_W-1] ? ~lim : lim;
  endfunction

  logic [ACC_W-1:0] raw_sel;
  logic             sat_now;

  assign raw_sel = acc_flat[sel*ACC_W +: ACC_W];
  assign ovf_out = guard_mismatch(raw_sel);
  assign sat_now = SAT_EN && sat_rd && ovf_out;
  assign acc_out = sat_now ? clamp(raw_sel) : raw_sel;
endmodule

// File: rtl/mac_dual_acc.sv
`timescale 1ns/1ps
module mac_dual_acc
  import mac_dual_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int ACC_W   = 40,
  parameter int RES_W   = 32,
  parameter int NUM_ACC = 2,
  parameter int SEL_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  parameter bit SAT_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic [1:0]       op_code,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic             clr,
  input  logic             sat_rd,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf_out
);
  mac_op_e                  op;
  logic [ACC_W-1:0]         prod_ext;
  logic [NUM_ACC*ACC_W-1:0] acc_flat;

  assign op = mac_op_e'(op_code);

  mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .a(op_a), .b(op_b), .a_sgn(a_signed), .b_sgn(b_signed), .prod_ext(prod_ext)
  );

  mac_acc_bank #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .sel(acc_sel),
    .clr(clr), .prod(prod_ext), .acc_flat(acc_flat)
  );

  mac_readout #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W), .RES_W(RES_W),
                .SEL_W(SEL_W), .SAT_EN(SAT_EN)) u_rd (
    .acc_flat(acc_flat), .sel(acc_sel), .sat_rd(sat_rd),
    .acc_out(acc_out), .ovf_out(ovf_out)
  );
endmodule

// File: rtl/mac_dual_acc_chk.sv
`timescale 1ns/1ps
module mac_dual_acc_chk
  import mac_dual_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int RES_W   = 32,
  parameter int NUM_ACC = 2,
  parameter int SEL_W   = 1,
  parameter bit SAT_EN  = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input mac_op_e                  op,
  input logic [SEL_W-1:0]         acc_sel,
  input logic                     clr,
  input logic                     sat_rd,
  input logic [ACC_W-1:0]         prod_ext,
  input logic [NUM_ACC*ACC_W-1:0] acc_flat,
  input logic [ACC_W-1:0]         acc_out,
  input logic                     ovf_out
);
  localparam logic [ACC_W-1:0] POS_LIM = {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  genvar i;
  generate
    for (i = 0; i < NUM_ACC; i++) begin : g_chk
      a_r6_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel != SEL_W'(i)) |=> $stable(acc_flat[i*ACC_W +: ACC_W]));
      a_r5_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && acc_sel == SEL_W'(i)) |=> (acc_flat[i*ACC_W +: ACC_W] == '0));
      a_r2_load_product: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr && op == OP_LOAD && acc_sel == SEL_W'(i))
          |=> (acc_flat[i*ACC_W +: ACC_W] == $past(prod_ext)));
    end
  endgenerate

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (!in_valid || op == OP_HOLD)) |=> $stable(acc_flat));

  a_r10_sat_extreme: assert property (@(posedge clk) disable iff (!rst_n)
    (SAT_EN && sat_rd && ovf_out) |-> (acc_out == POS_LIM || acc_out == NEG_LIM));

  a_r9_no_ovf_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_out |-> (acc_out == acc_flat[acc_sel*ACC_W +: ACC_W]));
endmodule

bind mac_dual_acc mac_dual_acc_chk #(
  .ACC_W(ACC_W), .RES_W(RES_W), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W), .SAT_EN(SAT_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc_sel(acc_sel),
  .clr(clr), .sat_rd(sat_rd), .prod_ext(prod_ext), .acc_flat(acc_flat),
  .acc_out(acc_out), .ovf_out(ovf_out)
);

// File: tb/mac_dual_acc_bench.sv
`timescale 1ns/1ps
module mac_dual_acc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        a_signed = 1'b0;
  logic        b_signed = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic        acc_sel = 1'b0;
  logic        clr = 1'b0;
  logic        sat_rd = 1'b0;
  logic [39:0] acc_out;
  logic        ovf_out;

  always #2 clk = ~clk;

  mac_dual_acc u_mac_dual_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .a_signed(a_signed), .b_signed(b_signed), .op_code(op_code),
    .acc_sel(acc_sel), .clr(clr), .sat_rd(sat_rd),
    .acc_out(acc_out), .ovf_out(ovf_out)
  );

  typedef struct {
    logic [39:0] val;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t   sb[$];
  longint model [2];
  int     checks = 0;
  int     errors = 0;
  bit     done = 1'b0;

  localparam longint M40 = 64'h00FF_FFFF_FFFF;

  function automatic longint to_s40(longint v);
    return v[39] ? (v - (64'sd1 <<< 40)) : v;
  endfunction

  // driver: apply one cycle of stimulus, update the model, queue the expectation
  task automatic drive(input bit v, input logic [1:0] oc, input logic [15:0] a,
                       input logic [15:0] b, input bit as_, input bit bs_,
                       input bit sel, input bit c, input bit sat, input string tag);
    longint av, bv, p, s;
    exp_t   e;
    @(negedge clk);
    in_valid = v; op_code = oc; op_a = a; op_b = b;
    a_signed = as_; b_signed = bs_; acc_sel = sel; clr = c; sat_rd = sat;
    av = as_ ? longint'($signed(a)) : longint'(a);
    bv = bs_ ? longint'($signed(b)) : longint'(b);
    p  = av * bv;
    if (c) model[sel] = 0;
    else if (v) begin
      case (oc)
        2'b01: model[sel] = p & M40;
        2'b10: model[sel] = (model[sel] + p) & M40;
        2'b11: model[sel] = (model[sel] - p) & M40;
        default: ;
      endcase
    end
    s = to_s40(model[sel]);
    e.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    if (sat && e.ovf) e.val = (s > 0) ? 40'h00_7FFF_FFFF : 40'hFF_8000_0000;
    else              e.val = model[sel][39:0];
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: registered state is visible just after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (acc_out !== e.val || ovf_out !== e.ovf) begin
        errors++;
        $display("FAIL %s: acc_out=%h ovf=%b expected acc_out=%h ovf=%b",
                 e.tag, acc_out, ovf_out, e.val, e.ovf);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    model[0] = 0; model[1] = 0;
    repeat (4) @(negedge clk);
    // R1: reset value visible directly
    checks++;
    if (acc_out !== 40'd0 || ovf_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: acc_out=%h ovf=%b expected 0 0", acc_out, ovf_out);
    end
    rst_n = 1'b1;
    drive(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R1 acc0 zero");
    drive(0, 2'b00, 0, 0, 0, 0, 1, 0, 0, "R1 acc1 zero");
    // R2 load, R8 signedness
    drive(1, 2'b01, 16'd300, 16'd200, 1, 1, 0, 0, 0, "R2 load pos");
    drive(1, 2'b01, 16'hFFFD, 16'd7, 1, 1, 0, 0, 0, "R8 signed neg*pos");
    drive(1, 2'b01, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 0, "R8 unsigned*unsigned");
    drive(1, 2'b01, 16'hFFFF, 16'hFFFF, 1, 0, 1, 0, 0, "R8 signed*unsigned");
    drive(1, 2'b01, 16'hFFFF, 16'hFFFF, 1, 1, 1, 0, 0, "R8 signed*signed");
    // R3 add, R4 subtract, R6 independence
    drive(1, 2'b10, 16'd1000, 16'd1000, 1, 1, 0, 0, 0, "R3 add");
    drive(1, 2'b11, 16'd50, 16'hFFFE, 1, 1, 0, 0, 0, "R4 sub neg product");
    drive(1, 2'b11, 16'd4000, 16'd4000, 1, 1, 1, 0, 0, "R4 sub");
    drive(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R6 acc0 untouched");
    // R7 hold
    drive(1, 2'b00, 16'd9, 16'd9, 1, 1, 0, 0, 0, "R7 hold opcode");
    drive(0, 2'b10, 16'd9, 16'd9, 1, 1, 0, 0, 0, "R7 invalid");
    // R5 clear with priority
    drive(1, 2'b10, 16'd9, 16'd9, 1, 1, 1, 1, 0, "R5 clear over add");
    drive(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R6 acc0 after clear of acc1");
    // R9 / R10 positive overflow
    drive(1, 2'b01, 16'h8000, 16'h8000, 1, 1, 0, 0, 0, "R2 load 2^30");
    drive(1, 2'b10, 16'h8000, 16'h8000, 1, 1, 0, 0, 0, "R9 overflow positive");
    drive(0, 2'b00, 0, 0, 0, 0, 0, 0, 1, "R10 clamp positive");
    drive(1, 2'b11, 16'h8000, 16'h8000, 1, 1, 0, 0, 1, "R9 back in range");
    // R9 / R10 negative overflow in acc1
    drive(1, 2'b11, 16'h8000, 16'h8000, 1, 1, 1, 0, 0, "R4 sub to -2^30");
    drive(1, 2'b11, 16'h8000, 16'h8000, 1, 1, 1, 0, 1, "R9 boundary -2^31");
    drive(1, 2'b11, 16'd1, 16'd1, 1, 1, 1, 0, 1, "R10 clamp negative");
    drive(0, 2'b00, 0, 0, 0, 0, 1, 0, 0, "R10 raw when sat off");
    // R11 wrap through long unsigned accumulation
    drive(1, 2'b00, 0, 0, 0, 0, 0, 1, 0, "R5 clear acc0");
    for (int k = 0; k < 300; k++)
      drive(1, 2'b10, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, k[0], "R11 wrap accumulate");
    // mixed patterns
    for (int k = 0; k < 200; k++)
      drive(1, 2'($urandom_range(0, 3)), 16'($urandom), 16'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), (k % 37) == 5,
            1'($urandom), "R3 R4 R8 mixed");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule